// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is one general-purpose I/O port of 32 pins behind a simple single-cycle register bus. Software writes output values and per-pin output enables, reads back synchronized input values, and sets up each pin as an interrupt source. Every register can be written in three ways: a plain overwrite, a write that only sets the bits given as 1, and a write that only clears the bits given as 1. With these, software can change one pin's configuration without a read-modify-write sequence.

Each pin input passes through a two-flop synchronizer. A per-pin trigger detector then compares the synchronized value with its value one cycle earlier. Two configuration bits select one of four trigger modes: falling edge, low level, rising edge or high level. A pin whose interrupt-select bit is set records its events in a sticky status register. The port drives one interrupt line that is high whenever any status bit is set and also enabled.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0 (the data-in view excepted, which shows the synchronized pins), `pin_o` and `pin_oe_o` are 0 and `irq_o` is low.
- R2: The output register (index 0, offset 0x00) drives `pin_o`, and the enable register (index 2, offset 0x20) drives `pin_oe_o`. A read returns the addressed register in the same cycle the request is presented.
- R3: Bits [6:4] of the address select the register and bits [3:0] select the write view: 0x0 overwrites, 0x4 ORs the data in, 0x8 clears the bits written as 1, and any other low nibble changes nothing. Reads return the register for any low nibble. An address with bit 7 set reads 0 and writes nothing.
- R4: The data-in view (offset 0x10) returns the pin values two clock edges after they are applied. Writes to it through any view change nothing.
- R5: With the level bit (offset 0x50) at 0, a pin triggers on an edge: polarity (offset 0x60) 1 means rising, 0 means falling. The status bit is set on the clock edge after the synchronized value changes, three edges after the pin changes.
- R6: With the level bit at 1, a pin triggers on every cycle its synchronized value equals its polarity bit, so clearing its status bit has no lasting effect while that level persists.
- R7: A pin whose interrupt-select bit (offset 0x30) is 0 never sets its status bit through hardware.
- R8: Status bits (offset 0x70) are sticky and fall only through a software write. When a hardware event and a software clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when status AND enable (offset 0x40) is nonzero, and it follows the registers without an extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | ADDR_W (8) | Byte address: register index and write view |
| wdata_i | input | N_PINS (32) | Write data |
| rdata_o | output | N_PINS (32) | Read data, combinational |
| pin_i | input | N_PINS (32) | Asynchronous pin inputs |
| pin_o | output | N_PINS (32) | Output values |
| pin_oe_o | output | N_PINS (32) | Per-pin output enables |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The trigger logic is tested with one pin in each of the four modes plus a fifth pin that is configured but not selected. All five are driven by the same pin transitions, so rising and falling edges are told apart from high and low levels, and the unselected pin shows that the select bit gates status. Clears are issued while a level is still active, which separates sticky edge events from level events that re-set their bit. A long phase of random writes through every view, interleaved with random pin toggles, is compared cycle by cycle against a behavioural model. This phase catches alias mix-ups, wrong read indexing and off-by-one synchronizer delays.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    IDX_DOUT = 3'd0, IDX_DIN = 3'd1, IDX_OE  = 3'd2, IDX_SEL  = 3'd3,
    IDX_EN   = 3'd4, IDX_LVL = 3'd5, IDX_POL = 3'd6, IDX_STAT = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLR} wr_op_e;

  function automatic wr_op_e decode_view(logic [3:0] lo);
    case (lo)
      4'h0:    return OP_WRITE;
      4'h4:    return OP_SET;
      4'h8:    return OP_CLR;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    always_comb begin
      if (level_i[i])    hit = ~(in_i[i] ^ pol_i[i]);
      else if (pol_i[i]) hit = in_i[i] & ~prev_q[i];
      else               hit = ~in_i[i] & prev_q[i];
    end
    assign evt_o[i] = hit & sel_i[i];
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  wr_op_e       op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, sw_next;

  always_comb begin
    case (op_i)
      OP_WRITE: sw_next = wdata_i;
      OP_SET:   sw_next = q | wdata_i;
      OP_CLR:   sw_next = q & ~wdata_i;
      default:  sw_next = q;
    endcase
  end

  // hardware set applied last so it wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= sw_next | hw_set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  localparam int OFS_W   = 4;
  localparam int IDX_W   = 3;
  localparam int REG_CNT = 1 << IDX_W;

  logic              hit, wr_en, stat_sw;
  logic [IDX_W-1:0]  idx;
  wr_op_e            op;
  logic [N_PINS-1:0] din_sync, evt;
  logic [N_PINS-1:0] regs_q [REG_CNT];

  assign hit   = (addr_i[ADDR_W-1:OFS_W+IDX_W] == '0);
  assign idx   = addr_i[OFS_W+IDX_W-1:OFS_W];
  assign op    = decode_view(addr_i[OFS_W-1:0]);
  assign wr_en = req_i & we_i & hit;
  assign stat_sw = wr_en && (idx == IDX_STAT) && (op != OP_NONE);

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(din_sync)
  );

  gpio_trig_detect #(.W(N_PINS)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(din_sync),
    .level_i(regs_q[IDX_LVL]), .pol_i(regs_q[IDX_POL]),
    .sel_i(regs_q[IDX_SEL]), .evt_o(evt)
  );

  for (genvar k = 0; k < REG_CNT; k++) begin : g_reg
    if (k == int'(IDX_DIN)) begin : g_ro
      assign regs_q[k] = din_sync;
    end else begin : g_rw
      wr_op_e            k_op;
      logic [N_PINS-1:0] k_hw;
      assign k_op = (wr_en && idx == IDX_W'(k)) ? op : OP_NONE;
      assign k_hw = (k == int'(IDX_STAT)) ? evt : '0;
      gpio_alias_reg #(.W(N_PINS)) u_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .op_i(k_op),
        .wdata_i(wdata_i), .hw_set_i(k_hw), .q_o(regs_q[k])
      );
    end
  end

  assign rdata_o  = hit ? regs_q[idx] : '0;
  assign pin_o    = regs_q[IDX_DOUT];
  assign pin_oe_o = regs_q[IDX_OE];
  assign irq_o    = |(regs_q[IDX_STAT] & regs_q[IDX_EN]);

  // R8: a status bit only falls after a software write to status
  assert_stat_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(regs_q[IDX_STAT]) & ~regs_q[IDX_STAT])) |-> $past(stat_sw));

  // R8: hardware set survives any same-cycle software view
  assert_hw_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((regs_q[IDX_STAT] & $past(evt)) == $past(evt)));

  // R7: unselected pins gain status only by software
  assert_unsel_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(regs_q[IDX_STAT] & ~$past(regs_q[IDX_STAT]) & ~$past(regs_q[IDX_SEL])))
      |-> $past(stat_sw));

  // R9: interrupt rises only from a pin event or a register write
  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt) != '0 || $past(wr_en)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, pout, poe;
  logic        irq;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model: register array plus pin history queue
  logic [31:0] m [8];
  logic [31:0] hist [$];

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a[7]) return '0;
    if (a[6:4] == 3'd1) return hist[1];
    return m[a[6:4]];
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a[6:4])
      3'd0, 3'd2: return "R2";
      3'd1:       return "R4";
      3'd3:       return "R7";
      3'd5, 3'd6: return "R5";
      3'd7:       return "R8";
      default:    return "R3";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = '0;
      hist = {32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev;
      int r;
      check("R2 pin_o", pout, m[0]);
      check("R2 pin_oe_o", poe, m[2]);
      check("R9 irq_o", {31'h0, irq}, {31'h0, |(m[7] & m[4])});
      if (req && !we) check({tag_of(addr), " R3 read"}, rdata, m_read(addr));
      ev = '0;
      for (int i = 0; i < 32; i++) begin
        bit s, p;
        s = hist[1][i]; p = hist[2][i];
        if (m[5][i])      ev[i] = (s == m[6][i]);
        else if (m[6][i]) ev[i] = s && !p;
        else              ev[i] = !s && p;
      end
      ev &= m[3];
      r = addr[6:4];
      if (req && we && !addr[7] && r != 1) begin
        case (addr[3:0])
          4'h0: m[r] = wdata;
          4'h4: m[r] = m[r] | wdata;
          4'h8: m[r] = m[r] & ~wdata;
          default: ;
        endcase
      end
      m[7] |= ev;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1; req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0;
  endtask

  task automatic rd_expect(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1; req = 1; we = 0; addr = a;
    @(negedge clk); check(tag, rdata, exp);
    @(posedge clk); #1; req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pins(logic [31:0] v);
    @(posedge clk); #1; pins = v;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(posedge clk); #1; rst_n = 1;
    // R1: reset state
    for (int i = 0; i < 8; i++) rd_expect(8'(i << 4), 32'h0, "R1 reset value");
    @(negedge clk);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 / R3: views
    wr(8'h00, 32'hA5A5_A5A5);
    wr(8'h04, 32'h0000_00F0);
    wr(8'h08, 32'hA000_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_expect(8'h00, 32'h05A5_A5F5, "R3 set/clear/none views");
    rd_expect(8'h04, 32'h05A5_A5F5, "R3 read via set view");
    wr(8'h20, 32'h0000_FFFF);
    @(negedge clk);
    check("R2 pin_o", pout, 32'h05A5_A5F5);
    check("R2 pin_oe_o", poe, 32'h0000_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd_expect(8'h80, 32'h0, "R3 out-of-range read");
    rd_expect(8'h00, 32'h05A5_A5F5, "R3 out-of-range write ignored");

    // R4: data-in
    set_pins(32'h1234_5678);
    idle(3);
    rd_expect(8'h10, 32'h1234_5678, "R4 din");
    wr(8'h10, 32'h0); wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    rd_expect(8'h10, 32'h1234_5678, "R4 din write ignored");

    // trigger modes: p0 fall, p1 low, p2 rise, p3 high, p4 rise unselected
    set_pins(32'h0000_0001);
    idle(4);
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h0000_000F);
    wr(8'h50, 32'h0000_000A);
    wr(8'h60, 32'h0000_001C);
    wr(8'h78, 32'hFFFF_FFFF);
    idle(2);
    rd_expect(8'h70, 32'h0000_0002, "R6 low level re-sets after clear");
    set_pins(32'h0000_001E);
    idle(4);
    rd_expect(8'h70, 32'h0000_000F, "R5 R7 edges, levels, unselected pin4");
    wr(8'h78, 32'h0000_000F);
    idle(2);
    rd_expect(8'h70, 32'h0000_0008, "R8 clear, R6 high level persists");
    set_pins(32'h0000_0000);
    idle(4);
    rd_expect(8'h70, 32'h0000_000A, "R5 no rise-edge event on fall");

    // R9: interrupt
    wr(8'h44, 32'h0000_0002);
    @(negedge clk);
    check("R9 irq on enabled status", {31'h0, irq}, 32'h1);
    set_pins(32'h0000_0002);
    idle(4);
    wr(8'h78, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // random phase, checked by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] lo;
      lo = 4'($urandom_range(0, 3) * 4);
      @(posedge clk); #1;
      req = ($urandom_range(0, 3) != 0);
      we  = ($urandom_range(0, 2) == 0);
      addr = {1'b0, 3'($urandom_range(0, 7)), lo};
      wdata = $urandom;
      if ($urandom_range(0, 3) == 0) pins = pins ^ (32'h1 << $urandom_range(0, 31));
    end
    @(posedge clk); #1; req = 0; we = 0;
    idle(2);
    finish_run();
  end
endmodule